// File: doc/BRIEF.md
# Timer Compare Output Unit

This unit watches a free-running timer value and compares it with a programmable compare register. When the timer steps onto the compare value, the unit acts on one output pin: it inverts the pin, drives it high, or drives it low. A 4-bit mode code selects the action. Each match event also sets a sticky interrupt flag, which software clears by writing a one.

The timer and its prescaler are outside the unit. The unit sees the timer value and a one-cycle step strobe. The strobe is high in the first clock cycle in which the timer shows a new value. When a prescaler is in use, the timer can rest on the compare value for several clocks. Qualifying matches with the step strobe makes the unit act only once for each timer increment.

The unit is controlled by a small state machine with six states:

- `ST_PORT`: the pin follows the port data latch.
- `ST_TOGGLE`: the pin inverts on each match.
- `ST_HI_ARMED`: the pin is held low and waits for a match.
- `ST_HI_DONE`: the pin is high after the match.
- `ST_LO_ARMED`: the pin follows the latch and waits for a match.
- `ST_LO_DONE`: the pin is low after the match.

The state machine has four kinds of transition:

- A mode write moves to the entry state of the new code, from any state.
- `ST_HI_ARMED` moves to `ST_HI_DONE` on a match event.
- `ST_LO_ARMED` moves to `ST_LO_DONE` on a match event.
- With no mode write and no match, every state holds.

Top module: `cmp_out_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pin output and the match flag are 0, the state is `ST_PORT` and the compare value is 0.
- R2: Mode code 4'b1000 (drive high). The write forces the pin to 0 on the next clock, whatever the port latch holds. The first match event then drives the pin to 1 on the following clock. The pin stays 1 until the next mode write.
- R3: Mode code 4'b1001 (drive low). Until the first match event, the pin takes the port latch value with one clock of delay. After the match it is 0 and ignores the latch until the next mode write.
- R4: Mode code 4'b0010 (toggle). The write loads the pin with the port latch value. Every match event then inverts the pin exactly once, and the port latch has no effect in this mode.
- R5: A match event needs the step strobe high and the timer value equal to the compare value in the same cycle. A timer that rests on the compare value for several cycles gives one event. A timer value equal to the compare value without the strobe gives none.
- R6: Every mode code other than 4'b0010, 4'b1000 and 4'b1001 makes the pin follow the port latch with one clock of delay and produces no match events; the flag stays 0.
- R7: A match event sets the flag on the next clock. The flag stays set until a cycle with the clear input high and no new event. An event in the same cycle as a clear leaves the flag set.
- R8: A compare write (write select 1, value on the data bus) is used for matching from the next clock on. A match against the old value in the cycle of the write still counts.
- R9: A mode write (write select 0, code on data bits 3:0) in the same cycle as a match event decides the pin and the next state. The event still sets the flag if the old mode was a compare mode.
- R10: Writing the mode code that is already active re-enters the mode: drive-high goes back to its pin-low armed state, and drive-low goes back to following the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = mode code, 1 = compare value |
| wr_data | input | 16 | Write data; the mode code is in bits 3:0 |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| tmr_val | input | 16 | Current timer value |
| tmr_step | input | 1 | High in the first cycle of a new timer value |
| port_latch | input | 1 | Port data latch level |
| pin_out | output | 1 | Compare output pin |
| match_flag | output | 1 | Sticky match interrupt flag |

## Verification
The hardest situation to reach from the ports is a mode write in the same cycle as a match. The write must take the pin while the flag still records the event. The bench gets there by driving the write strobe and the timer step onto the compare value in one half-cycle.

A compare write landing together with a match on the old value is built the same way. The multi-cycle rest of a prescaled timer is made by holding the timer value with the strobe low. The sweep covers all 16 mode codes against both latch levels and two prescale ratios, with the expected pin computed from the code, the latch level and the match count.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'b0010;
    localparam logic [MODE_W-1:0] MODE_HI     = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_LO     = 4'b1001;

    typedef enum logic [2:0] {
        ST_PORT     = 3'd0,
        ST_TOGGLE   = 3'd1,
        ST_HI_ARMED = 3'd2,
        ST_HI_DONE  = 3'd3,
        ST_LO_ARMED = 3'd4,
        ST_LO_DONE  = 3'd5
    } cmp_state_e;

    function automatic cmp_state_e entry_state(input logic [MODE_W-1:0] code);
        cmp_state_e s;
        case (code)
            MODE_TOGGLE: s = ST_TOGGLE;
            MODE_HI:     s = ST_HI_ARMED;
            MODE_LO:     s = ST_LO_ARMED;
            default:     s = ST_PORT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cmp_value_reg.sv
module cmp_value_reg #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             tmr_step,
    output logic             hit
);

    logic [TMR_W-1:0] cmp_q;

    // The new value lands at the clock edge; this cycle still matches against the old one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (load) begin
            cmp_q <= load_val;
        end
    end

    assign hit = tmr_step && (tmr_val == cmp_q);

endmodule

// File: rtl/cmp_pin_fsm.sv
module cmp_pin_fsm
    import cmp_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              hit,
    input  logic              port_latch,
    output logic              pin,
    output logic              cmp_active,
    output cmp_state_e        state
);

    cmp_state_e state_q, state_d, entry_s;
    logic       pin_q, pin_d, evt;

    assign entry_s    = entry_state(mode_code);
    assign cmp_active = (state_q != ST_PORT);
    assign evt        = hit && cmp_active;

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = entry_s;
        end else begin
            unique case (state_q)
                ST_HI_ARMED: if (evt) state_d = ST_HI_DONE;
                ST_LO_ARMED: if (evt) state_d = ST_LO_DONE;
                default:     state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PORT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pin_d = pin_q;
        if (mode_wr) begin
            pin_d = (entry_s == ST_HI_ARMED) ? 1'b0 : port_latch;
        end else begin
            unique case (state_q)
                ST_PORT:     pin_d = port_latch;
                ST_TOGGLE:   pin_d = evt ? ~pin_q : pin_q;
                ST_HI_ARMED: pin_d = evt;
                ST_HI_DONE:  pin_d = 1'b1;
                ST_LO_ARMED: pin_d = evt ? 1'b0 : port_latch;
                ST_LO_DONE:  pin_d = 1'b0;
                default:     pin_d = port_latch;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin   = pin_q;
    assign state = state_q;

endmodule

// File: rtl/cmp_irq_flag.sv
module cmp_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
    import cmp_out_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             flag_clr,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             tmr_step,
    input  logic             port_latch,
    output logic             pin_out,
    output logic             match_flag
);

    logic       cmp_wr, mode_wr, hit, cmp_active, hit_evt;
    cmp_state_e fsm_state;

    assign cmp_wr  = wr_en && wr_sel;
    assign mode_wr = wr_en && !wr_sel;

    cmp_value_reg #(.TMR_W(TMR_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmp_wr),
        .load_val (wr_data),
        .tmr_val  (tmr_val),
        .tmr_step (tmr_step),
        .hit      (hit)
    );

    cmp_pin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_code  (wr_data[MODE_W-1:0]),
        .hit        (hit),
        .port_latch (port_latch),
        .pin        (pin_out),
        .cmp_active (cmp_active),
        .state      (fsm_state)
    );

    assign hit_evt = hit && cmp_active;

    cmp_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit_evt),
        .clr   (flag_clr),
        .flag  (match_flag)
    );

endmodule

// File: rtl/cmp_out_chk.sv
module cmp_out_chk
    import cmp_out_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [MODE_W-1:0] mode_code,
    input logic              tmr_step,
    input logic              hit_evt,
    input logic              port_latch,
    input logic              flag_clr,
    input logic              pin_out,
    input logic              match_flag,
    input cmp_state_e        fsm_state
);

    logic mode_wr;
    assign mode_wr = wr_en && !wr_sel;

    AST_HI_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_code == MODE_HI) |=> !pin_out); // R2

    AST_HI_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HI_DONE && !mode_wr) |=> pin_out); // R2

    AST_LO_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_LO_DONE && !mode_wr) |=> !pin_out); // R3

    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_TOGGLE && !mode_wr && !tmr_step) |=> $stable(pin_out)); // R5

    AST_EVT_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_evt |-> tmr_step); // R5

    AST_PORT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PORT && !mode_wr) |=> (pin_out == $past(port_latch))); // R6

    AST_PORT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PORT && !match_flag) |=> !match_flag); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag); // R7

endmodule

bind cmp_out_unit cmp_out_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .mode_code  (wr_data[3:0]),
    .tmr_step   (tmr_step),
    .hit_evt    (hit_evt),
    .port_latch (port_latch),
    .flag_clr   (flag_clr),
    .pin_out    (pin_out),
    .match_flag (match_flag),
    .fsm_state  (fsm_state)
);

// File: tb/cmp_out_unit_tb_top.sv
module cmp_out_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] tmr_val = '0;
    logic        tmr_step = 1'b0;
    logic        port_latch = 1'b0;
    logic        pin_out, match_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_out_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_clr(flag_clr), .tmr_val(tmr_val), .tmr_step(tmr_step),
        .port_latch(port_latch), .pin_out(pin_out), .match_flag(match_flag)
    );

    task automatic check(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic step(input logic [15:0] v, input int hold);
        @(negedge clk);
        tmr_val = v; tmr_step = 1'b1;
        @(negedge clk);
        tmr_step = 1'b0;
        repeat (hold - 1) @(negedge clk);
    endtask

    function automatic logic exp_pin(input logic [3:0] m, input logic l, input int k);
        case (m)
            4'b0010: return l ^ k[0];
            4'b1000: return (k > 0);
            4'b1001: return (k > 0) ? 1'b0 : l;
            default: return l;
        endcase
    endfunction

    function automatic logic is_cmp(input logic [3:0] m);
        return (m == 4'b0010) || (m == 4'b1000) || (m == 4'b1001);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        port_latch = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pin in reset", pin_out, 1'b0);
        check("R1 flag in reset", match_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin follows latch after reset", pin_out, 1'b1);
        check("R1 flag after reset", match_flag, 1'b0);
        // R1: compare is 0, no mode selected: a step onto 0 sets nothing
        step(16'h0000, 1);
        check("R1 R6 no event at reset mode", match_flag, 1'b0);

        // Sweep: R2 R4 R6 with several prescale ratios
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 2; l++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [15:0] c;
                    int hold;
                    c = 16'h0100 + 16'(m * 7);
                    hold = (p == 0) ? 1 : 3;
                    port_latch = l[0];
                    wr(1'b1, c);
                    wr(1'b0, 16'(m));
                    check("R2 R4 R6 preload", pin_out,
                          (m == 8) ? 1'b0 : l[0]);
                    clear_flag();
                    step(c - 16'd1, 1);
                    for (int k = 1; k <= 3; k++) begin
                        step(c, hold);
                        check("R2 R3 R4 R5 R6 pin after match", pin_out,
                              exp_pin(4'(m), l[0], k));
                        check("R6 R7 flag after match", match_flag, is_cmp(4'(m)));
                        step(c + 16'd1, 1);
                    end
                end
            end
        end

        // R3: drive-low follows latch until the match
        port_latch = 1'b1;
        wr(1'b1, 16'h0200);
        wr(1'b0, 16'h0009);
        check("R3 armed follows latch 1", pin_out, 1'b1);
        @(negedge clk); port_latch = 1'b0;
        @(negedge clk);
        check("R3 armed follows latch 0", pin_out, 1'b0);
        port_latch = 1'b1;
        @(negedge clk);
        check("R3 armed follows latch 1 again", pin_out, 1'b1);
        step(16'h0200, 1);
        check("R3 low after match", pin_out, 1'b0);
        @(negedge clk); @(negedge clk);
        check("R3 latch ignored after match", pin_out, 1'b0);

        // R5: value equal without strobe gives no event
        port_latch = 1'b0;
        wr(1'b1, 16'h0300);
        wr(1'b0, 16'h0002);
        clear_flag();
        @(negedge clk); tmr_val = 16'h0300; tmr_step = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 no toggle without strobe", pin_out, 1'b0);
        check("R5 no flag without strobe", match_flag, 1'b0);
        // R4: latch has no effect in toggle
        port_latch = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R4 latch ignored in toggle", pin_out, 1'b0);
        port_latch = 1'b0;

        // R7: clear together with event keeps flag, clear alone drops it
        @(negedge clk);
        tmr_val = 16'h0300; tmr_step = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        tmr_step = 1'b0; flag_clr = 1'b0;
        check("R7 set wins over clear", match_flag, 1'b1);
        check("R7 toggle with clear", pin_out, 1'b1);
        clear_flag();
        check("R7 clear drops flag", match_flag, 1'b0);

        // R8: compare write with a match on the old value in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0400;
        tmr_val = 16'h0300; tmr_step = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tmr_step = 1'b0;
        check("R8 old value honoured", pin_out, 1'b0);
        check("R8 flag from old value", match_flag, 1'b1);
        step(16'h0300, 1);
        check("R8 old value retired", pin_out, 1'b0);
        step(16'h0400, 1);
        check("R8 new value matches", pin_out, 1'b1);

        // R9: mode write to drive-high in the cycle of a toggle match
        clear_flag();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0008;
        tmr_val = 16'h0400; tmr_step = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tmr_step = 1'b0;
        check("R9 write takes pin", pin_out, 1'b0);
        check("R9 event still flags", match_flag, 1'b1);
        step(16'h0401, 1);
        step(16'h0400, 1);
        check("R9 armed by the write", pin_out, 1'b1);

        // R10: rewrite of the same drive-high mode re-arms
        wr(1'b0, 16'h0008);
        check("R10 re-armed low", pin_out, 1'b0);
        step(16'h0401, 1);
        check("R10 waits for match", pin_out, 1'b0);
        step(16'h0400, 1);
        check("R10 high after new match", pin_out, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule